// File: doc/BRIEF.md
# Byte/Word Read-Only Memory Mode Front End

This block is the control and data front end of a small one-time-programmable memory. The memory can be read as 16-bit words or as 8-bit bytes. From a chip enable, an output enable, an organisation select and two high-voltage flags it works out the operating mode: read, identifier read, program, verify, or one of the floating states. It then drives the data bus through three separately enabled lanes. The low lane is bits 0 to 7. The high lane is bits 8 to 14. The shared lane is bit 15.

The shared pin is bit 15 of the data in word organisation. In byte organisation it becomes an address input, and it picks which half of the stored word appears on the low lane. The design has no tri-state nets. Each lane has its own output-enable signal, and that signal says whether the lane is driven. The storage is a parameterised array of registers. Reset sets every word to all ones, the erased value. A program operation can only clear bits. All outputs are registered, so the result for the inputs sampled at one clock edge appears just after that edge.

Top module: `rom_mode_frontend`

## Requirements
- R1: With the high-voltage program flag clear and chip enable (active low) high, all three lane enables are 0 after the next clock edge, whatever the output enable.
- R2: With chip enable low and output enable high, all three lane enables are 0 after the next clock edge.
- R3: Normal read in word organisation (select = 1, program flag clear, identifier flag clear, both enables low): all three lanes are enabled and `dq_o[15:0]` is the stored word at `addr_i`. Bit 15 is carried by the shared lane.
- R4: Normal read in byte organisation (select = 0) with `sh_addr_i` = 0: only the low lane is enabled, `dq_o[7:0]` is bits 7:0 of the stored word, and `dq_o[15:8]` is 0.
- R5: Byte organisation read with `sh_addr_i` = 1: `dq_o[7:0]` is bits 15:8 of the stored word. The lanes are as in R4.
- R6: Identifier read (identifier flag set, program flag clear, both enables low) in word organisation: `addr_i[0]` = 0 gives 16'h0020 and `addr_i[0]` = 1 gives 16'h00B2, with all three lanes enabled.
- R7: Identifier read in byte organisation: the same 8-bit code appears on `dq_o[7:0]` and only the low lane is enabled.
- R8: Program (program flag set, chip enable low, output enable high): at the clock edge the word at `addr_i` becomes its old value ANDed with `din_i`. No lane is enabled.
- R9: Verify (program flag set, chip enable high, output enable low): the full stored word is driven on all three lanes, whatever the organisation select.
- R10: Program inhibit (program flag set, both enables high): no lane is enabled and the array is left unchanged.
- R11: After reset, every lane enable and `dq_o` are 0, and every word reads 16'hFFFF.
- R12: Outputs change only at a clock edge. They reflect the inputs sampled at that edge, so an address change between edges leaves `dq_o` as it was until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| word_sel_i | input | 1 | 1 = word organisation, 0 = byte organisation |
| vpp_hi_i | input | 1 | Programming voltage present |
| id_hv_i | input | 1 | Identifier voltage present on address bit 9 |
| sh_addr_i | input | 1 | Shared pin as address input (byte half select) |
| din_i | input | 16 | Data to program |
| dq_o | output | 16 | Data bus value |
| lane_lo_oe_o | output | 1 | Drive enable for bits 7:0 |
| lane_hi_oe_o | output | 1 | Drive enable for bits 14:8 |
| sh_oe_o | output | 1 | Drive enable for shared pin (bit 15) |

## Verification
The identifier function and byte organisation can be active in the same cycle. The bench provokes this by raising the identifier flag while the select is low, with both `sh_addr_i` values and both `addr_i[0]` values. It then checks that the identifier code wins over array data while the narrow lane pattern is kept. A program cycle can also be followed at once by verify and by a byte read of the same word. The ANDed value has to be visible on the very next edge.

// File: rtl/rom_fe_pkg.sv
package rom_fe_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_READ,
    M_IDENT,
    M_PROG,
    M_VERIFY
  } fe_mode_e;
endpackage

// File: rtl/fe_mode_decode.sv
module fe_mode_decode
  import rom_fe_pkg::*;
(
  input  logic     ce_ni,
  input  logic     oe_ni,
  input  logic     vpp_hi_i,
  input  logic     id_hv_i,
  output fe_mode_e mode_o
);
  always_comb begin
    mode_o = M_IDLE;
    if (vpp_hi_i) begin
      case ({ce_ni, oe_ni})
        2'b00:   mode_o = M_READ;
        2'b01:   mode_o = M_PROG;
        2'b10:   mode_o = M_VERIFY;
        default: mode_o = M_IDLE;   // inhibit
      endcase
    end else if (!ce_ni && !oe_ni) begin
      mode_o = id_hv_i ? M_IDENT : M_READ;
    end
  end
endmodule

// File: rtl/fe_otp_array.sv
module fe_otp_array #(
  parameter int DEPTH  = 64,
  parameter int DW     = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g] <= '1;
      end else if (we_i && (addr_i == ADDR_W'(g))) begin
        word_q[g] <= word_q[g] & wdata_i;   // bits may only clear
      end
    end
  end

  assign rdata_o = word_q[addr_i];
endmodule

// File: rtl/fe_lane_mux.sv
module fe_lane_mux
  import rom_fe_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hB2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  fe_mode_e    mode_i,
  input  logic        word_sel_i,
  input  logic        sh_addr_i,
  input  logic        addr0_i,
  input  logic [15:0] rdata_i,
  output logic [15:0] dq_o,
  output logic        lane_lo_oe_o,
  output logic        lane_hi_oe_o,
  output logic        sh_oe_o
);
  logic [15:0] dq_d;
  logic        lo_d, hi_d, sh_d;

  always_comb begin
    dq_d = '0;
    lo_d = 1'b0;
    hi_d = 1'b0;
    sh_d = 1'b0;
    case (mode_i)
      M_READ: begin
        lo_d = 1'b1;
        if (word_sel_i) begin
          dq_d = rdata_i;
          hi_d = 1'b1;
          sh_d = 1'b1;
        end else begin
          dq_d = {8'h00, sh_addr_i ? rdata_i[15:8] : rdata_i[7:0]};
        end
      end
      M_IDENT: begin
        dq_d = {8'h00, addr0_i ? DEV_CODE : MFR_CODE};
        lo_d = 1'b1;
        hi_d = word_sel_i;
        sh_d = word_sel_i;
      end
      M_VERIFY: begin
        dq_d = rdata_i;
        lo_d = 1'b1;
        hi_d = 1'b1;
        sh_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o         <= '0;
      lane_lo_oe_o <= 1'b0;
      lane_hi_oe_o <= 1'b0;
      sh_oe_o      <= 1'b0;
    end else begin
      dq_o         <= dq_d;
      lane_lo_oe_o <= lo_d;
      lane_hi_oe_o <= hi_d;
      sh_oe_o      <= sh_d;
    end
  end
endmodule

// File: rtl/rom_mode_frontend.sv
module rom_mode_frontend
  import rom_fe_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              word_sel_i,
  input  logic              vpp_hi_i,
  input  logic              id_hv_i,
  input  logic              sh_addr_i,
  input  logic [15:0]       din_i,
  output logic [15:0]       dq_o,
  output logic              lane_lo_oe_o,
  output logic              lane_hi_oe_o,
  output logic              sh_oe_o
);
  fe_mode_e    mode;
  logic [15:0] rdata;

  fe_mode_decode u_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .vpp_hi_i (vpp_hi_i),
    .id_hv_i  (id_hv_i),
    .mode_o   (mode)
  );

  fe_otp_array #(.DEPTH(DEPTH), .DW(16), .ADDR_W(ADDR_W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode == M_PROG),
    .addr_i  (addr_i),
    .wdata_i (din_i),
    .rdata_o (rdata)
  );

  fe_lane_mux u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .word_sel_i   (word_sel_i),
    .sh_addr_i    (sh_addr_i),
    .addr0_i      (addr_i[0]),
    .rdata_i      (rdata),
    .dq_o         (dq_o),
    .lane_lo_oe_o (lane_lo_oe_o),
    .lane_hi_oe_o (lane_hi_oe_o),
    .sh_oe_o      (sh_oe_o)
  );
endmodule

// File: rtl/rom_mode_frontend_chk.sv
module rom_mode_frontend_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_ni,
  input logic        oe_ni,
  input logic        word_sel_i,
  input logic        vpp_hi_i,
  input logic        id_hv_i,
  input logic [15:0] dq_o,
  input logic        lane_lo_oe_o,
  input logic        lane_hi_oe_o,
  input logic        sh_oe_o
);
  p_standby_float_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !vpp_hi_i) |=> !(lane_lo_oe_o || lane_hi_oe_o || sh_oe_o));

  p_oe_high_float_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |=> !(lane_lo_oe_o || lane_hi_oe_o || sh_oe_o));

  p_lane_nest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_oe_o |-> (lane_hi_oe_o && lane_lo_oe_o));

  p_byte_narrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_sel_i && !vpp_hi_i) |=> (!lane_hi_oe_o && !sh_oe_o));

  p_id_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_hv_i && !vpp_hi_i && !ce_ni && !oe_ni) |=> (dq_o[15:8] == 8'h00 && lane_lo_oe_o));

  p_verify_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && ce_ni && !oe_ni) |=> (lane_lo_oe_o && lane_hi_oe_o && sh_oe_o));

  p_inhibit_float_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && ce_ni && oe_ni) |=> !(lane_lo_oe_o || lane_hi_oe_o || sh_oe_o));
endmodule

bind rom_mode_frontend rom_mode_frontend_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_ni        (ce_ni),
  .oe_ni        (oe_ni),
  .word_sel_i   (word_sel_i),
  .vpp_hi_i     (vpp_hi_i),
  .id_hv_i      (id_hv_i),
  .dq_o         (dq_o),
  .lane_lo_oe_o (lane_lo_oe_o),
  .lane_hi_oe_o (lane_hi_oe_o),
  .sh_oe_o      (sh_oe_o)
);

// File: tb/tb_rom_mode_frontend.sv
`timescale 1ns/1ps
module tb_rom_mode_frontend;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              ce_ni = 1'b1, oe_ni = 1'b1, word_sel_i = 1'b1;
  logic              vpp_hi_i = 1'b0, id_hv_i = 1'b0, sh_addr_i = 1'b0;
  logic [15:0]       din_i = '0;
  logic [15:0]       dq_o;
  logic              lane_lo_oe_o, lane_hi_oe_o, sh_oe_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model [DEPTH];

  always #5 clk_i = ~clk_i;

  rom_mode_frontend #(.DEPTH(DEPTH)) dut (.*);

  function automatic logic [15:0] pat_a(int a);
    return 16'(a * 16'h9E37) ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] pat_b(int a);
    return ~16'(a * 16'h0101 + 16'h0F0F);
  endfunction

  task automatic chk(string req, logic [2:0] oe_exp, logic [15:0] dq_exp);
    n_chk++;
    if ({lane_lo_oe_o, lane_hi_oe_o, sh_oe_o} !== oe_exp || dq_o !== dq_exp) begin
      n_fail++;
      $display("FAIL %s: oe=%b dq=%h expected oe=%b dq=%h", req,
               {lane_lo_oe_o, lane_hi_oe_o, sh_oe_o}, dq_o, oe_exp, dq_exp);
    end
  endtask

  task automatic step(logic ce, logic oe, logic vpp, logic id, logic ws,
                      logic sh, int a, logic [15:0] d);
    ce_ni = ce; oe_ni = oe; vpp_hi_i = vpp; id_hv_i = id; word_sel_i = ws;
    sh_addr_i = sh; addr_i = ADDR_W'(a); din_i = d;
    @(posedge clk_i); #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: oe=%b dq=%h expected completion", {lane_lo_oe_o, lane_hi_oe_o, sh_oe_o}, dq_o);
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R11 reset", 3'b000, 16'h0000);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R11 erased words, R3 word read
    for (int a = 0; a < DEPTH; a++) begin
      step(0, 0, 0, 0, 1, 0, a, 16'h0);
      chk("R11 erased word", 3'b111, 16'hFFFF);
    end

    // R8 program pattern, then a second pass that ANDs
    for (int a = 0; a < DEPTH; a++) begin
      step(0, 1, 1, 0, 1, 0, a, pat_a(a));
      model[a] = model[a] & pat_a(a);
      chk("R8 no drive while programming", 3'b000, 16'h0000);
    end
    for (int a = 0; a < DEPTH; a += 3) begin
      step(0, 1, 1, 0, 0, 1, a, pat_b(a));
      model[a] = model[a] & pat_b(a);
    end

    // R3 word read sweep
    for (int a = 0; a < DEPTH; a++) begin
      step(0, 0, 0, 0, 1, 0, a, 16'h0);
      chk("R3 word read", 3'b111, model[a]);
    end
    // R4 / R5 byte read sweep
    for (int a = 0; a < DEPTH; a++) begin
      step(0, 0, 0, 0, 0, 0, a, 16'h0);
      chk("R4 byte low half", 3'b100, {8'h00, model[a][7:0]});
      step(0, 0, 0, 0, 0, 1, a, 16'h0);
      chk("R5 byte high half", 3'b100, {8'h00, model[a][15:8]});
    end
    // R9 verify in both organisations
    for (int a = 0; a < DEPTH; a++) begin
      step(1, 0, 1, 0, a[0], 0, a, 16'hFFFF);
      chk("R9 verify", 3'b111, model[a]);
    end

    // R10 inhibit with zero data must not alter word 5
    step(1, 1, 1, 0, 1, 0, 5, 16'h0000);
    chk("R10 inhibit float", 3'b000, 16'h0000);
    step(0, 0, 0, 0, 1, 0, 5, 16'h0);
    chk("R10 array unchanged", 3'b111, model[5]);

    // R1 standby both oe levels, R2 oe high
    step(1, 0, 0, 0, 1, 0, 5, 16'h0);
    chk("R1 standby oe low", 3'b000, 16'h0000);
    step(1, 1, 0, 1, 1, 0, 5, 16'h0);
    chk("R1 standby oe high", 3'b000, 16'h0000);
    step(0, 1, 0, 0, 1, 0, 5, 16'h0);
    chk("R2 output disable", 3'b000, 16'h0000);
    step(0, 1, 0, 1, 0, 1, 6, 16'h0);
    chk("R2 output disable with id flag", 3'b000, 16'h0000);

    // R6 / R7 identifier in both organisations and both shared-pin levels
    for (int ws = 0; ws < 2; ws++)
      for (int sh = 0; sh < 2; sh++)
        for (int a0 = 0; a0 < 2; a0++) begin
          step(0, 0, 0, 1, ws[0], sh[0], 8 + a0, 16'h0);
          if (ws != 0) chk("R6 id word org", 3'b111, a0 != 0 ? 16'h00B2 : 16'h0020);
          else         chk("R7 id byte org", 3'b100, a0 != 0 ? 16'h00B2 : 16'h0020);
        end

    // R8 program then immediate verify and byte read of the same word
    step(0, 1, 1, 0, 1, 0, 7, 16'h0FF0);
    model[7] = model[7] & 16'h0FF0;
    step(1, 0, 1, 0, 1, 0, 7, 16'h0);
    chk("R8 read after program", 3'b111, model[7]);
    step(0, 0, 0, 0, 0, 1, 7, 16'h0);
    chk("R5 byte after program", 3'b100, {8'h00, model[7][15:8]});

    // R12 address change between edges does not move the output
    step(0, 0, 0, 0, 1, 0, 1, 16'h0);
    addr_i = ADDR_W'(2);
    #3;
    chk("R12 held between edges", 3'b111, model[1]);
    @(posedge clk_i); #1;
    chk("R12 updated at edge", 3'b111, model[2]);

    finish_run();
  end
endmodule